// File: doc/BRIEF.md
# Battery Protection FET Control Registers

This block holds the two control registers of a battery-protection controller. A host writes them through a one-cycle register-write port. From them the block drives the enables for the charge, discharge and precharge FETs and an open-drain status pin. It also drives the requests for the sleep and ship power modes.

Two fault sources are captured in sticky latches:
- current-limit events, which arrive as single-cycle digital pulses;
- a watchdog timeout on a 32 kHz reference clock.

While either latch is set, the charge and discharge FETs are held off. A latch is released only when software takes the clear bit through the full 0, 1, 0 sequence.

The watchdog synchronises the reference through two flops and looks for rising edges. It flags a fault when a programmable window of system clocks passes without an edge. One register bit turns the watchdog off.

Top module: `prot_fet_regs`

## Requirements
- R1: Address 0x01 is the output register. Bit 0 is the clear bit, bit 1 enables the discharge FET, bit 2 enables the charge FET, bit 3 is the precharge FET control and bit 4 enables the open-drain output. A read of 0x01 returns the stored bits, and bits 7:5 read as zero.
- R2: Address 0x02 is the state register. Bit 0 requests sleep, bit 1 arms ship mode and bit 2 disables the watchdog. A read of 0x02 returns these bits, and bits 7:3 read as zero. Any other read address returns zero.
- R3: Fault latches are released only when the clear bit has been written 1 and is then written 0. Writing 1 alone leaves them set, and they clear at the clock edge of the write of 0.
- R4: While any fault latch is set, `chg_fet_on` and `dsg_fet_on` are 0 whatever the register bits hold. With no fault, each of them follows its register bit.
- R5: At reset, the charge-FET bit takes the value of `strap_pack`. Every other register bit resets to 0, and both fault latches reset to clear.
- R6: The precharge control is inverted: a stored 0 gives `pre_fet_on`=1, and a stored 1 gives `pre_fet_on`=0.
- R7: `od_pull_low` is 1 exactly when the open-drain enable bit is 1.
- R8: `ship_req` is 1 only while the ship bit is set and `pack_present` is 0.
- R9: The watchdog fault latches when the reference input shows no rising edge for `WD_WINDOW` system clocks. A reference toggling well inside the window never latches it.
- R10: While the watchdog-disable bit is set, a stopped reference never latches the watchdog fault.
- R11: Writes to any address other than 0x01 and 0x02 change no register bit.
- R12: A current-limit pulse in the same cycle as a clear completion leaves the latch set.
- R13: `sleep_req` follows the sleep bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pack | input | 1 | Strap selecting the charge-FET reset value |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr` |
| ref_clk_in | input | 1 | 32 kHz reference, asynchronous |
| pack_present | input | 1 | High while the pack supply is applied |
| cl_pulse | input | 1 | Current-limit fault detect pulse |
| dsg_fet_on | output | 1 | Discharge FET enable |
| chg_fet_on | output | 1 | Charge FET enable |
| pre_fet_on | output | 1 | Precharge FET enable |
| od_pull_low | output | 1 | Drive the open-drain pin low |
| sleep_req | output | 1 | Sleep mode request |
| ship_req | output | 1 | Ship mode request |
| cl_fault | output | 1 | Current-limit fault latched |
| wd_fault | output | 1 | Watchdog fault latched |

## Verification
A current-limit detect pulse can arrive in the same clock cycle as the host write of 0 that completes the clear sequence. The bench sets up this collision on purpose: it writes 1 to the clear bit, then drives the pulse and the completing write together on one edge. The block must resolve it in favour of safety, so `cl_fault` must still read 1 and both FET enables must stay off. A separate clear sequence afterwards must then release the latch.

// File: rtl/prot_fet_pkg.sv
package prot_fet_pkg;

    typedef struct packed {
        logic od_en;
        logic pre_off;
        logic chg_en;
        logic dsg_en;
        logic lclr;
    } out_ctl_t;

    typedef struct packed {
        logic wd_off;
        logic ship;
        logic sleep;
    } st_ctl_t;

    typedef struct packed {
        out_ctl_t oc;
        st_ctl_t  sc;
    } ctl_regs_t;

endpackage

// File: rtl/pf_wdog.sv
module pf_wdog #(
    parameter int WD_WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic wd_off,
    output logic timeout
);
    localparam int CW = $clog2(WD_WINDOW + 1);

    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t  st_d, st_q;
    logic ref_rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], ref_in};
        ref_rise  = st_q.sync[1] & ~st_q.sync[2];
        timeout   = !wd_off && !ref_rise && (st_q.cnt == CW'(WD_WINDOW - 1));
        if (wd_off || ref_rise || timeout) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: the count never passes the window
    a_r9_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(WD_WINDOW));

    // R10: monitoring is held off while disabled
    a_r10_off_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        wd_off |=> (st_q.cnt == '0));

endmodule

// File: rtl/pf_fault_latch.sv
module pf_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cl,
    input  logic set_wd,
    input  logic clr,
    output logic cl_q,
    output logic wd_q
);
    typedef struct packed {
        logic cl;
        logic wd;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d.cl = set_cl | (lat_q.cl & ~clr);
        lat_d.wd = set_wd | (lat_q.wd & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign cl_q = lat_q.cl;
    assign wd_q = lat_q.wd;

    // R12: a detect pulse always wins over a clear
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_cl |=> cl_q);

    // R3: the latch is sticky without a clear
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_q && !clr) |=> cl_q);

    // R3: a clear without a new detect releases the latch
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_cl) |=> !cl_q);

endmodule

// File: rtl/prot_fet_regs.sv
module prot_fet_regs #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int WD_WINDOW = 64,
    parameter logic [ADDR_W-1:0] OUT_ADDR = 'h01,
    parameter logic [ADDR_W-1:0] ST_ADDR  = 'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pack,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ref_clk_in,
    input  logic              pack_present,
    input  logic              cl_pulse,
    output logic              dsg_fet_on,
    output logic              chg_fet_on,
    output logic              pre_fet_on,
    output logic              od_pull_low,
    output logic              sleep_req,
    output logic              ship_req,
    output logic              cl_fault,
    output logic              wd_fault
);
    import prot_fet_pkg::*;

    localparam int OC_W = $bits(out_ctl_t);
    localparam int SC_W = $bits(st_ctl_t);

    ctl_regs_t regs_d, regs_q, rst_val;
    logic      clr_pulse;
    logic      wd_timeout;
    logic      any_fault;
    logic      unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:OC_W];

    always_comb begin
        rst_val           = '0;
        rst_val.oc.chg_en = strap_pack;
    end

    always_comb begin
        regs_d    = regs_q;
        clr_pulse = 1'b0;
        if (wr_en && addr == OUT_ADDR) begin
            regs_d.oc = out_ctl_t'(wr_data[OC_W-1:0]);
            clr_pulse = regs_q.oc.lclr && !wr_data[0];
        end else if (wr_en && addr == ST_ADDR) begin
            regs_d.sc = st_ctl_t'(wr_data[SC_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= rst_val;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        if (addr == OUT_ADDR) begin
            rd_data = DATA_W'(regs_q.oc);
        end else if (addr == ST_ADDR) begin
            rd_data = DATA_W'(regs_q.sc);
        end else begin
            rd_data = '0;
        end
    end

    pf_wdog #(.WD_WINDOW(WD_WINDOW)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_in  (ref_clk_in),
        .wd_off  (regs_q.sc.wd_off),
        .timeout (wd_timeout)
    );

    pf_fault_latch u_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_cl (cl_pulse),
        .set_wd (wd_timeout),
        .clr    (clr_pulse),
        .cl_q   (cl_fault),
        .wd_q   (wd_fault)
    );

    assign any_fault   = cl_fault | wd_fault;
    assign dsg_fet_on  = regs_q.oc.dsg_en & ~any_fault;
    assign chg_fet_on  = regs_q.oc.chg_en & ~any_fault;
    assign pre_fet_on  = ~regs_q.oc.pre_off;
    assign od_pull_low = regs_q.oc.od_en;
    assign sleep_req   = regs_q.sc.sleep;
    assign ship_req    = regs_q.sc.ship & ~pack_present;

    // R8: never request ship while the pack supply is present
    a_r8_ship_needs_no_pack: assert property (@(posedge clk) disable iff (!rst_n)
        ship_req |-> !pack_present);

    // R4: FETs held off while a latched fault exists
    a_r4_fault_blocks_fets: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_fault || wd_fault) |-> (!chg_fet_on && !dsg_fet_on));

    // R11: unmapped writes leave the registers untouched
    a_r11_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != OUT_ADDR && addr != ST_ADDR) |=> $stable(regs_q));

endmodule

// File: tb/prot_fet_regs_test.sv
`timescale 1ns/1ps
module prot_fet_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_pack = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ref_clk_in = 1'b0;
    logic       pack_present = 1'b1;
    logic       cl_pulse = 1'b0;
    logic       dsg_fet_on, chg_fet_on, pre_fet_on, od_pull_low;
    logic       sleep_req, ship_req, cl_fault, wd_fault;
    logic       ref_run = 1'b1;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    prot_fet_regs #(.WD_WINDOW(64)) uut (
        .clk(clk), .rst_n(rst_n), .strap_pack(strap_pack), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .ref_clk_in(ref_clk_in), .pack_present(pack_present), .cl_pulse(cl_pulse),
        .dsg_fet_on(dsg_fet_on), .chg_fet_on(chg_fet_on), .pre_fet_on(pre_fet_on),
        .od_pull_low(od_pull_low), .sleep_req(sleep_req), .ship_req(ship_req),
        .cl_fault(cl_fault), .wd_fault(wd_fault)
    );

    // slow reference: toggles every 8 system clocks while running
    initial begin
        forever begin
            repeat (8) @(negedge clk);
            if (ref_run) ref_clk_in = ~ref_clk_in;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        strap_pack = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        rd_check("R5 chg strap high", 8'h01, 8'h04);
        check("R5 chg on after reset", chg_fet_on, 1);
        do_reset(1'b0);
        rd_check("R5 out reg strap low", 8'h01, 8'h00);
        rd_check("R5 state reg", 8'h02, 8'h00);
        check("R5 faults clear", {cl_fault, wd_fault}, 0);
        check("R6 pre on by default", pre_fet_on, 1);
    endtask

    task automatic t_regs;
        wr(8'h01, 8'hFE);
        rd_check("R1 out readback", 8'h01, 8'h1E);
        check("R6 pre off when set", pre_fet_on, 0);
        check("R7 od active", od_pull_low, 1);
        check("R4 fets follow bits", {chg_fet_on, dsg_fet_on}, 2'b11);
        wr(8'h01, 8'h06);
        check("R7 od released", od_pull_low, 0);
        check("R6 pre on again", pre_fet_on, 1);
        wr(8'h02, 8'hF9);
        rd_check("R2 state readback", 8'h02, 8'h01);
        check("R13 sleep req", sleep_req, 1);
        rd_check("R2 unmapped read zero", 8'h05, 8'h00);
        wr(8'h00, 8'hFF);
        wr(8'h03, 8'hFF);
        wr(8'hFF, 8'h00);
        rd_check("R11 out unchanged", 8'h01, 8'h06);
        rd_check("R11 state unchanged", 8'h02, 8'h01);
        wr(8'h02, 8'h00);
        check("R13 sleep dropped", sleep_req, 0);
    endtask

    task automatic t_ship;
        wr(8'h02, 8'h02);
        pack_present = 1'b1;
        #1 check("R8 ship blocked by pack", ship_req, 0);
        pack_present = 1'b0;
        #1 check("R8 ship with no pack", ship_req, 1);
        wr(8'h02, 8'h00);
        check("R8 ship disarmed", ship_req, 0);
        pack_present = 1'b1;
    endtask

    task automatic t_clear;
        @(negedge clk); cl_pulse = 1'b1;
        @(negedge clk); cl_pulse = 1'b0;
        check("R3 cl latched", cl_fault, 1);
        check("R4 fets forced off", {chg_fet_on, dsg_fet_on}, 2'b00);
        wr(8'h01, 8'h07);
        check("R3 half sequence holds", cl_fault, 1);
        wr(8'h01, 8'h06);
        check("R3 full sequence clears", cl_fault, 0);
        check("R4 fets restored", {chg_fet_on, dsg_fet_on}, 2'b11);
        wr(8'h01, 8'h07);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h01; wr_data = 8'h06; cl_pulse = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cl_pulse = 1'b0;
        check("R12 set wins over clear", cl_fault, 1);
        check("R12 fets stay off", {chg_fet_on, dsg_fet_on}, 2'b00);
        wr(8'h01, 8'h07);
        wr(8'h01, 8'h06);
        check("R12 later clear works", cl_fault, 0);
    endtask

    task automatic t_wdog;
        repeat (100) @(negedge clk);
        check("R9 no fault with ref running", wd_fault, 0);
        ref_run = 1'b0;
        repeat (80) @(negedge clk);
        check("R9 fault on stopped ref", wd_fault, 1);
        check("R4 wd blocks fets", {chg_fet_on, dsg_fet_on}, 2'b00);
        ref_run = 1'b1;
        repeat (40) @(negedge clk);
        wr(8'h01, 8'h07);
        wr(8'h01, 8'h06);
        check("R3 wd fault cleared", wd_fault, 0);
        wr(8'h02, 8'h04);
        ref_run = 1'b0;
        repeat (150) @(negedge clk);
        check("R10 disabled no fault", wd_fault, 0);
        ref_run = 1'b1;
        repeat (20) @(negedge clk);
        wr(8'h02, 8'h00);
        repeat (100) @(negedge clk);
        check("R9 re-enabled quiet", wd_fault, 0);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_ship();
        t_clear();
        t_wdog();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule